// File: doc/BRIEF.md
# Manchester IR Frame Receiver

This block takes the demodulated, active-low output of an infrared receiver module and recovers a 64-bit payload sent as a Manchester-coded frame. The line idles high. The receiver arms only after the line has been high for an idle period of 5 ms. It then treats the first falling edge as the centre of the first bit.

Each bit is sampled a quarter-bit after its centre transition. The sample timer restarts on every accepted centre transition, so drift between the sender's clock and the local clock is absorbed bit by bit rather than accumulating over the frame. Edges that fall outside the tolerance windows end the frame with an error. So does a missing centre transition.

Recovered bits are shifted in most significant first. A frame counts as good only when its top 16 bits are all ones. All timing is derived from a clock-frequency parameter.

Top module: `ir_manchester_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `valid_o` and `error_o` are 0 and `payload_o` is all zeros.
- R2: A falling edge is taken as a frame start only after the synchronised line has been high for the idle time (5 ms) without a break. A frame that begins earlier is ignored: it produces neither `valid_o` nor `error_o`.
- R3: Bit encoding is as follows. A falling transition at the bit centre encodes 1 and a rising one encodes 0. Bits fill `payload_o` from bit 63 down to bit 0. At the end of a good frame, `valid_o` pulses high for exactly one clock, and `payload_o` changes only in that cycle.
- R4: A frame whose upper 16 bits differ from 0xFFFF raises `error_o` for one clock instead of `valid_o`, and `payload_o` keeps its previous value. The two strobes are never high together.
- R5: Centre-to-centre intervals within ±30 % of the nominal full-bit time are accepted, as are centre-to-boundary intervals within ±30 % of the nominal 889 µs half-bit. Frames sent at 0.8× and 1.2× the nominal bit period decode correctly.
- R6: An edge arriving after a centre transition but before 70 % of the half-bit time aborts the frame with a one-clock `error_o`. So does an edge falling between the half-bit and full-bit windows.
- R7: If no centre transition arrives within 130 % of the full-bit time, the frame is aborted with a one-clock `error_o`.
- R8: Because the sample timer restarts on each accepted centre transition, a sender running about 2 % slow still decodes correctly over all 64 bits.
- R9: After an error, the receiver again requires the full idle time before it arms. A frame starting sooner is ignored, and a later good frame decodes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock, frequency given by CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_line_i | input | 1 | Demodulated IR line, idle high, asynchronous to clk |
| payload_o | output | 64 | Last good payload, most significant bit received first |
| valid_o | output | 1 | One-clock strobe when a good frame completes |
| error_o | output | 1 | One-clock strobe on a timing fault, timeout or header mismatch |

## Verification
The assertions assume that the input line makes clean, single transitions whose spacing is a whole number of clock cycles. They also assume that any frame reaching the decoder starts from an idle-high line. The bench drives the line only on falling clock edges and holds it high between frames. It gives each intended frame more than the idle time of quiet line beforehand, except where it deliberately starts a frame early to exercise the arming rule. Timing faults are introduced only as a deliberate short glitch or a frame cut off mid-way, so every other edge stays inside the tolerance windows.

// File: rtl/ir_rx_pkg.sv
// Package: shared state type and timing helpers for the Manchester IR receiver.
// Assumes clock rates and durations small enough that their product fits 64 bits.
package ir_rx_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_IDLE,
        ST_ARMED,
        ST_RECV
    } rx_state_e;

    // Number of clock cycles in a duration given in microseconds.
    function automatic int cycles_of(input longint unsigned clk_hz, input longint unsigned dur_us);
        return int'((clk_hz * dur_us) / 64'd1_000_000);
    endfunction

    // Scale a cycle count by a percentage, rounding down.
    function automatic int scale_pct(input int value, input int pct);
        return (value * pct) / 100;
    endfunction

endpackage

// File: rtl/ir_rx_sync.sv
// Two-flop synchroniser for the asynchronous IR line, plus a third flop for
// edge detection. Assumes the line idles high, so all flops reset to 1.
module ir_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic meta_q, sync_q, prev_q;

    // Purpose: bring the line into the clock domain and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;
    assign rise_o  = sync_q & ~prev_q;
    assign fall_o  = ~sync_q & prev_q;
endmodule

// File: rtl/ir_rx_idle_detect.sv
// Counts consecutive high cycles on the synchronised line. Reports idle once
// IDLE_CYC cycles have passed. A low level or the clear input restarts the count.
module ir_rx_idle_detect #(
    parameter int IDLE_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic level_i,
    output logic idle_o
);
    localparam int CNT_W = $clog2(IDLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_CYC);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: saturating count of high cycles since the last low level or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i || !level_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idle_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/ir_rx_window.sv
// Classifies the time since the last accepted centre transition into the
// boundary window, the centre window and the timeout region. Purely
// combinational. Assumes the tolerance is small enough that the windows do
// not overlap.
module ir_rx_window #(
    parameter int HALF_CYC = 889,
    parameter int TOL_PCT  = 30,
    parameter int TMR_W    = 12
) (
    input  logic [TMR_W-1:0] timer_i,
    output logic             in_half_o,
    output logic             in_full_o,
    output logic             late_o
);
    import ir_rx_pkg::*;

    localparam int FULL_CYC = 2 * HALF_CYC;
    localparam logic [TMR_W-1:0] HALF_LO = TMR_W'(scale_pct(HALF_CYC, 100 - TOL_PCT));
    localparam logic [TMR_W-1:0] HALF_HI = TMR_W'(scale_pct(HALF_CYC, 100 + TOL_PCT));
    localparam logic [TMR_W-1:0] FULL_LO = TMR_W'(scale_pct(FULL_CYC, 100 - TOL_PCT));
    localparam logic [TMR_W-1:0] FULL_HI = TMR_W'(scale_pct(FULL_CYC, 100 + TOL_PCT));

    // Purpose: compare the timer against the four window bounds.
    always_comb begin
        in_half_o = (timer_i >= HALF_LO) && (timer_i <= HALF_HI);
        in_full_o = (timer_i >= FULL_LO) && (timer_i <= FULL_HI);
        late_o    = (timer_i > FULL_HI);
    end
endmodule

// File: rtl/ir_manchester_rx.sv
// Manchester IR frame receiver. Waits for an idle-high line, locks onto the
// first falling edge as a bit centre and samples each bit a quarter-bit after
// its centre. It restarts the sample timer on every accepted centre edge and
// checks the header at the end of the frame. Assumes ir_line_i is the
// demodulated, active-low receiver output, asynchronous to clk.
module ir_manchester_rx #(
    parameter int              CLK_HZ    = 1_000_000,
    parameter int              HALF_US   = 889,
    parameter int              IDLE_US   = 5000,
    parameter int              TOL_PCT   = 30,
    parameter int              PAYLOAD_W = 64,
    parameter int              HDR_W     = 16,
    parameter logic [HDR_W-1:0] HDR_VAL  = 16'hFFFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ir_line_i,
    output logic [PAYLOAD_W-1:0] payload_o,
    output logic                 valid_o,
    output logic                 error_o
);
    import ir_rx_pkg::*;

    localparam int HALF_CYC   = cycles_of(CLK_HZ, HALF_US);
    localparam int SAMPLE_CYC = HALF_CYC / 2;
    localparam int IDLE_CYC   = cycles_of(CLK_HZ, IDLE_US);
    localparam int FULL_HI    = scale_pct(2 * HALF_CYC, 100 + TOL_PCT);
    localparam int TMR_W      = $clog2(FULL_HI + 2);
    localparam int BIT_W      = $clog2(PAYLOAD_W);
    localparam logic [TMR_W-1:0] SAMPLE_T = TMR_W'(SAMPLE_CYC);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(PAYLOAD_W - 1);

    logic                 line_lvl, line_rise, line_fall, line_edge;
    logic                 idle_ok, idle_clr_q;
    logic                 in_half, in_full, too_late;
    rx_state_e            state_q;
    logic [TMR_W-1:0]     timer_q;
    logic [BIT_W-1:0]     bit_cnt_q;
    logic [PAYLOAD_W-1:0] shift_q, shift_nxt;
    logic                 hdr_ok;

    ir_rx_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ir_line_i),
        .level_o (line_lvl),
        .rise_o  (line_rise),
        .fall_o  (line_fall)
    );

    ir_rx_idle_detect #(.IDLE_CYC(IDLE_CYC)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (idle_clr_q),
        .level_i (line_lvl),
        .idle_o  (idle_ok)
    );

    ir_rx_window #(.HALF_CYC(HALF_CYC), .TOL_PCT(TOL_PCT), .TMR_W(TMR_W)) u_win (
        .timer_i   (timer_q),
        .in_half_o (in_half),
        .in_full_o (in_full),
        .late_o    (too_late)
    );

    assign line_edge = line_rise | line_fall;
    // A low line after the centre edge means a falling centre, i.e. a 1.
    assign shift_nxt = {shift_q[PAYLOAD_W-2:0], ~line_lvl};
    assign hdr_ok    = (shift_nxt[PAYLOAD_W-1 -: HDR_W] == HDR_VAL);

    // Purpose: frame state machine, sample timer, bit shifting and result strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_WAIT_IDLE;
            timer_q    <= '0;
            bit_cnt_q  <= '0;
            shift_q    <= '0;
            payload_o  <= '0;
            valid_o    <= 1'b0;
            error_o    <= 1'b0;
            idle_clr_q <= 1'b0;
        end else begin
            valid_o    <= 1'b0;
            error_o    <= 1'b0;
            idle_clr_q <= 1'b0;
            unique case (state_q)
                ST_WAIT_IDLE: begin
                    if (idle_ok) state_q <= ST_ARMED;
                end
                ST_ARMED: begin
                    if (line_fall) begin
                        state_q   <= ST_RECV;
                        timer_q   <= '0;
                        bit_cnt_q <= '0;
                    end
                end
                ST_RECV: begin
                    if (line_edge) begin
                        if (in_full) begin
                            timer_q <= '0;
                        end else if (in_half) begin
                            timer_q <= timer_q + 1'b1;
                        end else begin
                            error_o    <= 1'b1;
                            idle_clr_q <= 1'b1;
                            state_q    <= ST_WAIT_IDLE;
                        end
                    end else if (too_late) begin
                        error_o    <= 1'b1;
                        idle_clr_q <= 1'b1;
                        state_q    <= ST_WAIT_IDLE;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                        if (timer_q == SAMPLE_T) begin
                            shift_q <= shift_nxt;
                            if (bit_cnt_q == LAST_BIT) begin
                                idle_clr_q <= 1'b1;
                                state_q    <= ST_WAIT_IDLE;
                                if (hdr_ok) begin
                                    payload_o <= shift_nxt;
                                    valid_o   <= 1'b1;
                                end else begin
                                    error_o <= 1'b1;
                                end
                            end else begin
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end
                    end
                end
                default: state_q <= ST_WAIT_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ir_manchester_rx_chk.sv
// Checker for the Manchester IR receiver outputs, bound to every instance of
// the top module. Assumes a synchronous active-low reset.
module ir_manchester_rx_chk #(
    parameter int               PAYLOAD_W = 64,
    parameter int               HDR_W     = 16,
    parameter logic [HDR_W-1:0] HDR_VAL   = 16'hFFFF
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 valid_o,
    input logic                 error_o,
    input logic [PAYLOAD_W-1:0] payload_o
);
    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R3
    payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(payload_o));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && error_o));

    // R4
    header_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (payload_o[PAYLOAD_W-1 -: HDR_W] == HDR_VAL));

    // R6
    error_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |=> !error_o);
endmodule

bind ir_manchester_rx ir_manchester_rx_chk #(
    .PAYLOAD_W (PAYLOAD_W),
    .HDR_W     (HDR_W),
    .HDR_VAL   (HDR_VAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_o   (valid_o),
    .error_o   (error_o),
    .payload_o (payload_o)
);

// File: tb/ir_manchester_rx_test.sv
// Bench: clock 100 kHz in the design's timing terms (half-bit 88 cycles,
// idle 500 cycles), driven at 250 MHz in simulation time.
module ir_manchester_rx_test;
    localparam int HALF_NOM = 88;

    typedef struct packed {
        logic [63:0] data;
        logic [31:0] half;
        logic        good;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{64'hFFFF_0078_9243_0000, 32'd88,  1'b1, 8'd3},
        '{64'hFFFF_A5A5_5A5A_0001, 32'd70,  1'b1, 8'd5},
        '{64'hFFFF_1234_5678_9ABC, 32'd106, 1'b1, 8'd5},
        '{64'hFFFF_FFFF_FFFF_FFFF, 32'd88,  1'b1, 8'd3},
        '{64'hFFFF_0000_0000_0000, 32'd88,  1'b1, 8'd3},
        '{64'hFFFF_8001_7FFE_C003, 32'd90,  1'b1, 8'd8},
        '{64'hFFFE_DEAD_BEEF_0000, 32'd88,  1'b0, 8'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line = 1'b1;
    logic [63:0] payload;
    logic        valid, error;

    int tests = 0;
    int fails = 0;
    int vcnt = 0;
    int ecnt = 0;
    logic [63:0] seen_payload = '0;
    logic [63:0] exp_payload = '0;

    always #2 clk = ~clk;

    ir_manchester_rx #(.CLK_HZ(100_000)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ir_line_i (line),
        .payload_o (payload),
        .valid_o   (valid),
        .error_o   (error)
    );

    // Count strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n && valid) begin
            vcnt++;
            seen_payload = payload;
        end
        if (rst_n && error) ecnt++;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        line = v;
        repeat (n) @(negedge clk);
    endtask

    // Sends bits MSB first; glitch_bit inserts a short pulse 20 cycles after
    // that bit's centre; stop_bit releases the line high before that bit.
    task automatic send_frame(input logic [63:0] d, input int half, input int glitch_bit, input int stop_bit);
        for (int k = 0; k < 64; k++) begin
            logic b;
            if (k == stop_bit) begin
                line = 1'b1;
                return;
            end
            b = d[63-k];
            hold(b, half);
            if (k == glitch_bit) begin
                hold(~b, 20);
                hold(b, 5);
                hold(~b, half - 25);
            end else begin
                hold(~b, half);
            end
        end
        line = 1'b1;
    endtask

    task automatic expect_counts(input int v0, input int e0, input int dv, input int de, input string req);
        check(vcnt - v0 == dv, req, 64'(vcnt - v0), 64'(dv));
        check(ecnt - e0 == de, req, 64'(ecnt - e0), 64'(de));
        check(payload === exp_payload, req, payload, exp_payload);
    endtask

    initial begin
        repeat (195_000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int v0, e0;
        // R1: outputs during reset and just after it.
        repeat (3) @(negedge clk);
        check(!valid && !error && payload == '0, "R1", {payload[61:0], valid, error}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!valid && !error && payload == '0, "R1", {payload[61:0], valid, error}, 64'd0);

        // R2: frame starting before the idle time has elapsed is ignored.
        hold(1'b1, 200);
        v0 = vcnt; e0 = ecnt;
        send_frame(64'hFFFF_1111_2222_3333, HALF_NOM, -1, -1);
        hold(1'b1, 40);
        expect_counts(v0, e0, 0, 0, "R2");

        // Table of frames: R3 R4 R5 R8.
        foreach (VECS[i]) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            hold(1'b1, 600);
            v0 = vcnt; e0 = ecnt;
            send_frame(VECS[i].data, int'(VECS[i].half), -1, -1);
            hold(1'b1, 40);
            if (VECS[i].good) exp_payload = VECS[i].data;
            expect_counts(v0, e0, VECS[i].good ? 1 : 0, VECS[i].good ? 0 : 1, tag);
            if (VECS[i].good) check(seen_payload === VECS[i].data, tag, seen_payload, VECS[i].data);
        end

        // R6: short glitch after a centre edge aborts the frame.
        hold(1'b1, 600);
        v0 = vcnt; e0 = ecnt;
        send_frame(64'hFFFF_4444_5555_6666, HALF_NOM, 5, 8);
        hold(1'b1, 300);
        expect_counts(v0, e0, 0, 1, "R6");

        // R7: frame cut off after 10 bits times out.
        hold(1'b1, 600);
        v0 = vcnt; e0 = ecnt;
        send_frame(64'hFFFF_7777_8888_9999, HALF_NOM, -1, 10);
        hold(1'b1, 300);
        expect_counts(v0, e0, 0, 1, "R7");

        // R9: a frame right after the error is ignored, a later one decodes.
        v0 = vcnt; e0 = ecnt;
        send_frame(64'hFFFF_ABCD_EF01_2345, HALF_NOM, -1, 20);
        hold(1'b1, 40);
        expect_counts(v0, e0, 0, 0, "R9");
        hold(1'b1, 600);
        v0 = vcnt; e0 = ecnt;
        send_frame(64'hFFFF_0F0F_F0F0_3C3C, HALF_NOM, -1, -1);
        hold(1'b1, 40);
        exp_payload = 64'hFFFF_0F0F_F0F0_3C3C;
        expect_counts(v0, e0, 1, 0, "R9");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule